// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers single-cycle event pulses from several sources into sticky flags and drives a single active-low, open-drain interrupt line. The line is represented by an output-enable, `irq_oe`. When it is high, the pad pulls the line low. When it is low, the line floats. An enable register turns each source's effect on the line on or off one at a time. A flag is still recorded while its source is disabled, so enabling that source later raises the line at once.

Software releases the line by writing a dedicated clear register. A write clears every sticky flag only if at least one of two designated bits in the written word is 1. By default these are bits 6 and 7. A write with neither bit set does nothing.

The line never changes while the bus target reports a transaction in progress. A change that builds up during a transaction is applied on the first clock edge after the busy flag drops. Address decoding is not part of this block. The bus target supplies separate write strobes for the enable register and the clear register.

Top module: `irq_aggregator`

## Requirements
- R1: After reset `irq_oe` is 0 and every source is enabled, so that an event pulse with no prior enable write asserts the line.
- R2: With `bus_busy` low, a pulse on an enabled source in the cycle before edge k sets its flag at edge k and sets `irq_oe` at edge k+1.
- R3: A pulse on a source whose enable bit is 0 leaves `irq_oe` at 0.
- R4: A flag recorded while its source was disabled asserts `irq_oe` two edges after an enable write that sets its bit.
- R5: A clear write whose bit 6 is 1 clears all flags, and `irq_oe` falls one edge after the write edge.
- R6: A clear write whose bit 7 is 1 has the same effect as R5, whatever the value of bit 6.
- R7: A clear write with bits 6 and 7 both 0 has no effect on the flags or on `irq_oe`, for every value of the other bits.
- R8: An event pulse in the same cycle as an effective clear write survives the clear, and its flag still asserts `irq_oe`.
- R9: While `bus_busy` is sampled high, `irq_oe` holds its value. A pending change is applied at the first edge where `bus_busy` is sampled low.
- R10: `irq_oe` follows the OR of the flags ANDed with the enable bits, so disabling every pending source releases the line while the flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | N_EVT | Single-cycle event pulses, one per source |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | N_EVT | New enable bits, 1 = source drives the line |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_wdata | input | REG_W | Clear register data; bits CLR_BIT_A/CLR_BIT_B trigger the clear |
| bus_busy | input | 1 | High while a bus transaction is in progress |
| irq_oe | output | 1 | Pin output-enable, 1 = pull the interrupt line low |

## Verification
The bench builds the block with four sources and an 8-bit clear register, with the clear bits left at 6 and 7. This makes it practical to sweep every pairing of a 16-value enable mask with a 16-value event pattern, and to check both the masked result and the result after a later unmask. The small register width also allows every one of the 256 clear-word values to be tried against a set flag. Hold-off during busy and the case of an event arriving together with a clear are then exercised on this small setup.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    PIN_RELEASED = 1'b0,
    PIN_DRIVEN   = 1'b1
  } pin_state_e;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [N_EVT-1:0] wdata,
  output logic [N_EVT-1:0] en_q
);
  localparam logic [N_EVT-1:0] EN_RESET = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= EN_RESET;
    else if (wr) en_q <= wdata;
  end
endmodule

// File: rtl/irq_clr_decode.sv
module irq_clr_decode #(
  parameter int REG_W     = 8,
  parameter int CLR_BIT_A = 6,
  parameter int CLR_BIT_B = 7
) (
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             clear_hit
);
  localparam logic [REG_W-1:0] ONE_HOT_A = REG_W'(1) << CLR_BIT_A;
  localparam logic [REG_W-1:0] ONE_HOT_B = REG_W'(1) << CLR_BIT_B;
  localparam logic [REG_W-1:0] CLR_MASK  = ONE_HOT_A | ONE_HOT_B;

  function automatic logic hits(input logic [REG_W-1:0] d);
    return |(d & CLR_MASK);
  endfunction

  assign clear_hit = wr & hits(wdata);
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic             clear,
  output logic [N_EVT-1:0] flag_q
);
  // a new event wins over a clear arriving in the same cycle
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_next(flag_q[i], evt[i], clear);
    end
  end
endmodule

// File: rtl/irq_pin_hold.sv
module irq_pin_hold
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic hold,
  output logic oe
);
  pin_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= PIN_RELEASED;
    else if (!hold) state_q <= want ? PIN_DRIVEN : PIN_RELEASED;
  end

  assign oe = (state_q == PIN_DRIVEN);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_EVT     = 8,
  parameter int REG_W     = 8,
  parameter int CLR_BIT_A = 6,
  parameter int CLR_BIT_B = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic             en_wr,
  input  logic [N_EVT-1:0] en_wdata,
  input  logic             clr_wr,
  input  logic [REG_W-1:0] clr_wdata,
  input  logic             bus_busy,
  output logic             irq_oe
);
  logic [N_EVT-1:0] flag_q;
  logic [N_EVT-1:0] en_q;
  logic             clear_hit;
  logic             irq_want;

  function automatic logic any_enabled(input logic [N_EVT-1:0] f, input logic [N_EVT-1:0] e);
    return |(f & e);
  endfunction

  irq_en_reg #(.N_EVT(N_EVT)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata), .en_q(en_q)
  );

  irq_clr_decode #(.REG_W(REG_W), .CLR_BIT_A(CLR_BIT_A), .CLR_BIT_B(CLR_BIT_B)) u_dec (
    .wr(clr_wr), .wdata(clr_wdata), .clear_hit(clear_hit)
  );

  irq_sticky #(.N_EVT(N_EVT)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clear(clear_hit), .flag_q(flag_q)
  );

  assign irq_want = any_enabled(flag_q, en_q);

  irq_pin_hold u_pin (
    .clk(clk), .rst_n(rst_n), .want(irq_want), .hold(bus_busy), .oe(irq_oe)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_EVT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_pulse,
  input logic             bus_busy,
  input logic             irq_oe,
  input logic [N_EVT-1:0] flag_q,
  input logic             irq_want,
  input logic             clear_hit
);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> $stable(irq_oe));

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |=> (irq_oe == $past(irq_want)));

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> ($past(irq_want) && !$past(bus_busy)));

  // R4
  flag_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R8
  evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_hit && (|evt_pulse)) |=> (flag_q == $past(evt_pulse)));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_hit && !(|evt_pulse)) |=> (flag_q == '0));

  // R7
  no_clear_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_hit |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_busy(bus_busy),
  .irq_oe(irq_oe), .flag_q(flag_q), .irq_want(irq_want), .clear_hit(clear_hit)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int NE = 4;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_pulse = '0;
  logic          en_wr = 1'b0;
  logic [NE-1:0] en_wdata = '0;
  logic          clr_wr = 1'b0;
  logic [RW-1:0] clr_wdata = '0;
  logic          bus_busy = 1'b0;
  logic          irq_oe;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_aggregator #(.N_EVT(NE), .REG_W(RW), .CLR_BIT_A(6), .CLR_BIT_B(7)) uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .bus_busy(bus_busy), .irq_oe(irq_oe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_vec++;
    if (irq_oe !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_oe=%b expected=%b at cycle %0d", req, irq_oe, exp, cyc);
    end
  endtask

  task automatic pulse(input logic [NE-1:0] p);
    evt_pulse = p; tick(); evt_pulse = '0;
  endtask

  task automatic write_en(input logic [NE-1:0] m);
    en_wr = 1'b1; en_wdata = m; tick(); en_wr = 1'b0;
  endtask

  task automatic write_clr(input logic [RW-1:0] d);
    clr_wr = 1'b1; clr_wdata = d; tick(); clr_wr = 1'b0; clr_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    tick(); tick();
    // R1: released line after reset
    check("R1", 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1", 1'b0);
    // R1: all sources enabled by default
    pulse(4'b1000);
    check("R1", 1'b0);  // flag set, pin one edge later
    tick();
    check("R1", 1'b1);
    write_clr(8'h40); tick();
    check("R5", 1'b0);

    // R2/R3/R4/R5/R6: sweep every enable mask against every event pattern
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        write_en(NE'(m));
        pulse(NE'(p)); tick();
        check(((m & p) != 0) ? "R2" : "R3", ((m & p) != 0));
        write_en('1); tick();
        check("R4", (p != 0));
        write_clr(((p & 1) != 0) ? 8'h80 : 8'h40); tick();
        check(((p & 1) != 0) ? "R6" : "R5", 1'b0);
      end
    end

    // R5/R6/R7: every clear word against a set flag
    for (int d = 0; d < 256; d++) begin
      pulse(4'b0001); tick();
      write_clr(RW'(d)); tick();
      check((d[7]) ? "R6" : ((d[6]) ? "R5" : "R7"), !(d[6] || d[7]));
      write_clr(8'hC0); tick();
    end

    // R8: event in the same cycle as an effective clear
    pulse(4'b0010); tick();
    evt_pulse = 4'b0100; clr_wr = 1'b1; clr_wdata = 8'hC0;
    tick();
    evt_pulse = '0; clr_wr = 1'b0; clr_wdata = '0;
    tick();
    check("R8", 1'b1);
    write_en(4'b1011); tick();
    check("R8", 1'b0);  // only the simultaneous event's flag remains
    write_en('1); tick();
    check("R8", 1'b1);
    write_clr(8'h40); tick();

    // R9: hold-off while busy, assert
    bus_busy = 1'b1;
    pulse(4'b0001);
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R9", 1'b0);
    end
    bus_busy = 1'b0;
    check("R9", 1'b0);
    tick();
    check("R9", 1'b1);
    // R9: hold-off while busy, release
    bus_busy = 1'b1;
    write_clr(8'h80);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R9", 1'b1);
    end
    bus_busy = 1'b0;
    tick();
    check("R9", 1'b0);

    // R10: disabling the pending source releases the line, flag kept
    pulse(4'b0100); tick();
    check("R10", 1'b1);
    write_en(4'b1011); tick();
    check("R10", 1'b0);
    write_en(4'b0100); tick();
    check("R10", 1'b1);
    write_clr(8'hFF); tick();
    check("R10", 1'b0);

    finish_run();
  end
endmodule